// File: doc/BRIEF.md
# Routed System Interrupt Controller

This block gathers 32 level-sensitive peripheral interrupt lines and passes each one that is both active and enabled to one of nine core priority lines, numbered 7 through 15. Every source has its own programmable 4-bit routing field, so software decides which core priority a peripheral raises. No fixed priority encoding is involved. When several enabled sources are routed to the same priority line, their requests are ORed together on that line.

Software reaches the block through a small word-addressed register port. The port covers an enable mask, four routing registers holding eight fields each, a read-only snapshot of the input levels, a wakeup-enable register, and three 16-bit system words. The system words always read as zero and ignore writes. Each access carries a size code. An access of an unsupported size is refused with an error flag and changes no state.

Top module: `sys_irq_router`

## Requirements
- R1: Status bit n holds the level that `irq_in[n]` had at the previous clock edge. It is read as a 32-bit word at byte offset 0x20.
- R2: A source drives a priority line only while both its status bit and its mask bit (register at offset 0x0C) are 1. With all pending sources masked, `prio_out` is all zeros.
- R3: The routing field of source n occupies bits [(n%8)*4+3:(n%8)*4] of routing register n/8. Routing registers 0 to 3 sit at offsets 0x10, 0x14, 0x18 and 0x1C. A pending source with field value v asserts `prio_out[v]`, which stands for core priority 7+v.
- R4: Each `prio_out` bit is the OR of all pending sources routed to it. It stays high while any of them remains pending and falls once none is.
- R5: A source whose field value is 9 to 15 drives no output at all.
- R6: Writes to the status word (0x20) are ignored. Writes to the system words at 0x00, 0x04 and 0x08 are discarded, and those words read as zero.
- R7: Mask, routing and wakeup (0x24) registers accept writes and return the written value on a 32-bit read. Read data and the error flag appear in the cycle after the access cycle.
- R8: The size code is 2'b01 for 16-bit and 2'b10 for 32-bit. Any other code raises `bus_err` for one cycle after the access, writes nothing, and returns zero read data.
- R9: A read of an unmapped word (offset 0x28 and above) returns zero. A 16-bit read returns the low half of the register, zero-extended. A 16-bit write stores the low half of the write data with the upper half cleared. Address bits [1:0] are ignored.
- R10: After reset, mask and status are zero, wakeup is all ones, and routing registers 0 to 3 hold 0x22211000, 0x43333332, 0x55555444 and 0x66655555.
- R11: A change on `irq_in` reaches `prio_out` two clock edges later. A write to the mask or a routing register reaches `prio_out` one clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Peripheral interrupt levels |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Illegal-size flag, registered |
| prio_out | output | 9 | Core priority requests; bit v = priority 7+v |

## Verification
Routing is exercised first with one active source at a time under the reset routing table, and then with sources chosen across all four routing registers and at field boundaries. This tells a correct nibble position apart from an off-by-one field or a wrong register index. Two sources sharing a line are raised together and then released one at a time, which distinguishes a true OR from a last-writer-wins encoder. Out-of-range fields are mixed with valid ones to show that dropping a source does not disturb its neighbours. Input, mask and routing changes are sampled on the edges just before and just after they are due, which exposes any extra or missing pipeline stage.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam int PRIO_BASE = 7;
  // word indices of the register map
  localparam int W_SWRST  = 0;
  localparam int W_SYSCFG = 1;
  localparam int W_RVEC   = 2;
  localparam int W_MASK   = 3;
  localparam int W_ROUTE0 = 4;

  function automatic logic [31:0] route_reset(input int idx);
    case (idx)
      0: route_reset = 32'h2221_1000;
      1: route_reset = 32'h4333_3332;
      2: route_reset = 32'h5555_5444;
      3: route_reset = 32'h6665_5555;
      default: route_reset = 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= irq_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 4,
  parameter int ADDR_W  = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [1:0]                    bus_size,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [DATA_W-1:0]             status_i,
  output logic [DATA_W-1:0]             mask_o,
  output logic [DATA_W*FIELD_W-1:0]     route_o,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          bus_err
);
  localparam int NUM_GRP  = FIELD_W;          // DATA_W sources, DATA_W/FIELD_W per register
  localparam int WORD_W   = ADDR_W - 2;
  localparam int HALF_W   = DATA_W / 2;
  localparam int W_STATUS = W_ROUTE0 + NUM_GRP;
  localparam int W_WAKE   = W_STATUS + 1;

  logic [WORD_W-1:0] word;
  logic              size_ok, is_half, wr_en, rd_en;
  logic [DATA_W-1:0] wval, rd_mux;
  logic [DATA_W-1:0] mask_q, wake_q, rdata_q;
  logic [DATA_W-1:0] route_q [NUM_GRP];
  logic              err_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign is_half = (bus_size == SZ_HALF);
  assign size_ok = is_half || (bus_size == SZ_WORD);
  assign wr_en   = bus_valid && bus_write && size_ok;
  assign rd_en   = bus_valid && !bus_write && size_ok;
  assign wval    = is_half ? {{HALF_W{1'b0}}, bus_wdata[HALF_W-1:0]} : bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      wake_q <= '1;
    end else if (wr_en) begin
      if (word == WORD_W'(W_MASK)) mask_q <= wval;
      if (word == WORD_W'(W_WAKE)) wake_q <= wval;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)
        route_q[g] <= DATA_W'(route_reset(g));
      else if (wr_en && word == WORD_W'(W_ROUTE0 + g))
        route_q[g] <= wval;
    end
    assign route_o[g*DATA_W +: DATA_W] = route_q[g];
  end

  always_comb begin
    rd_mux = '0;
    if (word == WORD_W'(W_MASK))   rd_mux = mask_q;
    if (word == WORD_W'(W_STATUS)) rd_mux = status_i;
    if (word == WORD_W'(W_WAKE))   rd_mux = wake_q;
    for (int g = 0; g < NUM_GRP; g++)
      if (word == WORD_W'(W_ROUTE0 + g)) rd_mux = route_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= bus_valid && !size_ok;
      if (rd_en)
        rdata_q <= is_half ? {{HALF_W{1'b0}}, rd_mux[HALF_W-1:0]} : rd_mux;
      else
        rdata_q <= '0;
    end
  end

  assign mask_o    = mask_q;
  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R8
  bad_size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_size != SZ_HALF && bus_size != SZ_WORD)
      |=> ($stable(mask_q) && $stable(wake_q) && bus_err && bus_rdata == '0));

  // R10
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && wake_q == '1 && route_q[0] == DATA_W'(route_reset(0))));

  // R6
  sysreg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (bus_size == SZ_HALF || bus_size == SZ_WORD)
      && bus_addr[ADDR_W-1:2] <= WORD_W'(W_RVEC)) |=> (bus_rdata == '0));
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int NUM_SRC  = 32,
  parameter int FIELD_W  = 4,
  parameter int NUM_PRIO = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          status_i,
  input  logic [NUM_SRC-1:0]          mask_i,
  input  logic [NUM_SRC*FIELD_W-1:0]  route_i,
  output logic [NUM_PRIO-1:0]         prio_o
);
  logic [NUM_SRC-1:0]  pend;
  logic [NUM_PRIO-1:0] hit, prio_q;

  assign pend = status_i & mask_i;

  for (genvar k = 0; k < NUM_PRIO; k++) begin : g_line
    logic [NUM_SRC-1:0] sel;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign sel[n] = (route_i[n*FIELD_W +: FIELD_W] == FIELD_W'(k));
    end
    assign hit[k] = |(pend & sel);
  end

  always_ff @(posedge clk) begin
    if (rst) prio_q <= '0;
    else     prio_q <= hit;
  end

  assign prio_o = prio_q;

  // R2
  no_pend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (prio_q == '0));

  // R5
  prio_count_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(prio_q) <= $countones($past(pend))));
endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router #(
  parameter int NUM_SRC  = 32,
  parameter int FIELD_W  = 4,
  parameter int NUM_PRIO = 9,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [NUM_SRC-1:0]  bus_wdata,
  output logic [NUM_SRC-1:0]  bus_rdata,
  output logic                bus_err,
  output logic [NUM_PRIO-1:0] prio_out
);
  logic [NUM_SRC-1:0]         status;
  logic [NUM_SRC-1:0]         mask;
  logic [NUM_SRC*FIELD_W-1:0] route;

  sirq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .irq_i(irq_in), .status_o(status)
  );

  sirq_regs #(.DATA_W(NUM_SRC), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .status_i(status), .mask_o(mask), .route_o(route),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  sirq_route #(.NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_PRIO(NUM_PRIO)) u_route (
    .clk(clk), .rst(rst), .status_i(status), .mask_i(mask),
    .route_i(route), .prio_o(prio_out)
  );
endmodule

// File: tb/sys_irq_router_bench.sv
module sys_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [8:0]  prio_out;

  int errors = 0, checks = 0;
  logic [31:0] mask_m = '0;
  logic [31:0] rt_m [4];
  logic [31:0] rd;
  logic        er;

  always #2 clk = ~clk;

  sys_irq_router u_sys_irq_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .prio_out(prio_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_prio(input logic [31:0] lv);
    logic [8:0] r = '0;
    logic [31:0] p = lv & mask_m;
    for (int n = 0; n < 32; n++) begin
      logic [3:0] f = rt_m[n/8][(n%8)*4 +: 4];
      if (p[n] && f <= 4'd8) r[f] = 1'b1;
    end
    return r;
  endfunction

  task automatic access(input logic w, input logic [5:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] r, output logic e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    r = bus_rdata; e = bus_err;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 prio after reset", 32'(prio_out), 32'h0);
    access(0, 6'h0C, 2'b10, 0, rd, er); chk("R10 mask reset", rd, 32'h0);
    access(0, 6'h20, 2'b10, 0, rd, er); chk("R10 status reset", rd, 32'h0);
    access(0, 6'h24, 2'b10, 0, rd, er); chk("R10 wakeup reset", rd, 32'hFFFF_FFFF);
    for (int g = 0; g < 4; g++) begin
      access(0, 6'(6'h10 + 4*g), 2'b10, 0, rd, er); chk("R10 route reset", rd, rt_m[g]);
    end
  endtask

  task automatic t_status;
    set_irq(32'hA5A5_0F0F);
    access(0, 6'h20, 2'b10, 0, rd, er); chk("R1 status pattern", rd, 32'hA5A5_0F0F);
    set_irq(32'h0);
    access(0, 6'h20, 2'b10, 0, rd, er); chk("R1 status cleared", rd, 32'h0);
  endtask

  task automatic t_mask;
    set_irq(32'hFFFF_FFFF);
    chk("R2 all masked", 32'(prio_out), 32'h0);
    access(1, 6'h0C, 2'b10, 32'h1, rd, er); mask_m = 32'h1;
    @(negedge clk);
    chk("R2 one enabled", 32'(prio_out), 32'h1);
    set_irq(32'h0);
  endtask

  task automatic t_route;
    int srcs [9] = '{0, 3, 5, 8, 15, 16, 19, 29, 31};
    access(1, 6'h0C, 2'b10, 32'hFFFF_FFFF, rd, er); mask_m = 32'hFFFF_FFFF;
    foreach (srcs[i]) begin
      set_irq(32'h1 << srcs[i]);
      chk("R3 default route", 32'(prio_out), 32'(exp_prio(32'h1 << srcs[i])));
    end
    set_irq(32'h0);
  endtask

  task automatic t_share_drop;
    // src9 -> 8, src10 -> 9 (dropped), src11 -> 8, src8 -> 0
    access(1, 6'h14, 2'b10, 32'h0000_8980, rd, er); rt_m[1] = 32'h0000_8980;
    set_irq(32'h0000_0A00);
    chk("R4 two share line", 32'(prio_out), 32'h100);
    set_irq(32'h0000_0200);
    chk("R4 one of two left", 32'(prio_out), 32'h100);
    set_irq(32'h0000_0400);
    chk("R5 field 9 dropped", 32'(prio_out), 32'h0);
    set_irq(32'h0000_0500);
    chk("R5 drop beside valid", 32'(prio_out), 32'h1);
    set_irq(32'h0);
    chk("R4 all released", 32'(prio_out), 32'h0);
  endtask

  task automatic t_timing;
    @(negedge clk); irq_in = 32'h1;
    @(negedge clk); chk("R11 input one edge", 32'(prio_out), 32'h0);
    @(negedge clk); chk("R11 input two edges", 32'(prio_out), 32'h1);
    access(1, 6'h0C, 2'b10, 32'h0, rd, er); mask_m = 32'h0;
    chk("R11 mask write edge", 32'(prio_out), 32'h1);
    @(negedge clk); chk("R11 mask next edge", 32'(prio_out), 32'h0);
    access(1, 6'h0C, 2'b10, 32'hFFFF_FFFF, rd, er); mask_m = 32'hFFFF_FFFF;
    @(negedge clk);
    access(1, 6'h10, 2'b10, 32'h0000_0007, rd, er); rt_m[0] = 32'h7;
    chk("R11 route write edge", 32'(prio_out), 32'h1);
    @(negedge clk); chk("R11 route next edge", 32'(prio_out), 32'h80);
    set_irq(32'h0);
  endtask

  task automatic t_ignore;
    set_irq(32'h0000_F00D);
    access(1, 6'h20, 2'b10, 32'hFFFF_FFFF, rd, er);
    access(0, 6'h20, 2'b10, 0, rd, er); chk("R6 status write ignored", rd, 32'h0000_F00D);
    for (int w = 0; w < 3; w++) begin
      access(1, 6'(4*w), 2'b01, 32'hFFFF, rd, er);
      access(0, 6'(4*w), 2'b01, 0, rd, er); chk("R6 system word zero", rd, 32'h0);
    end
    set_irq(32'h0);
  endtask

  task automatic t_size;
    access(0, 6'h0C, 2'b10, 0, rd, er); chk("R8 legal no error", 32'(er), 32'h0);
    access(1, 6'h0C, 2'b00, 32'h1234_5678, rd, er); chk("R8 byte write error", 32'(er), 32'h1);
    access(0, 6'h0C, 2'b10, 0, rd, er); chk("R8 mask unchanged", rd, mask_m);
    access(0, 6'h24, 2'b11, 0, rd, er); chk("R8 bad read error", 32'(er), 32'h1);
    chk("R8 bad read data zero", rd, 32'h0);
  endtask

  task automatic t_width;
    access(0, 6'h28, 2'b10, 0, rd, er); chk("R9 unmapped word", rd, 32'h0);
    access(0, 6'h3C, 2'b01, 0, rd, er); chk("R9 unmapped half", rd, 32'h0);
    access(1, 6'h24, 2'b01, 32'hABCD_1234, rd, er);
    access(0, 6'h24, 2'b10, 0, rd, er); chk("R9 half write", rd, 32'h0000_1234);
    access(0, 6'h1E, 2'b01, 0, rd, er); chk("R9 half read low bits ignored", rd, rt_m[3] & 32'hFFFF);
  endtask

  task automatic t_rw;
    access(1, 6'h24, 2'b10, 32'h5A5A_C3C3, rd, er);
    access(0, 6'h24, 2'b10, 0, rd, er); chk("R7 wakeup rw", rd, 32'h5A5A_C3C3);
    access(1, 6'h0C, 2'b10, 32'hDEAD_BEEF, rd, er); mask_m = 32'hDEAD_BEEF;
    access(0, 6'h0C, 2'b10, 0, rd, er); chk("R7 mask rw", rd, 32'hDEAD_BEEF);
    access(1, 6'h18, 2'b10, 32'h1357_9BDF, rd, er); rt_m[2] = 32'h1357_9BDF;
    access(0, 6'h18, 2'b10, 0, rd, er); chk("R7 route rw", rd, 32'h1357_9BDF);
  endtask

  initial begin
    rt_m[0] = 32'h2221_1000; rt_m[1] = 32'h4333_3332;
    rt_m[2] = 32'h5555_5444; rt_m[3] = 32'h6665_5555;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_status();
    t_mask();
    t_route();
    t_share_drop();
    t_timing();
    t_ignore();
    t_size();
    t_width();
    t_rw();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule